// File: doc/BRIEF.md
# Periodic Interrupt and Watchdog Timer

This block runs a free-running binary prescaler chain from the bus clock and derives two timing services from it. A two-bit rate field picks one of four deep chain stages. Each 0-to-1 transition of the picked stage sets a sticky periodic flag, which raises an interrupt when software has enabled it. The same transitions also advance a small watchdog stage counter. If software does not strobe the watchdog clear before a fixed number of these transitions has passed, the block emits a one-cycle watchdog reset pulse.

Software sees two byte-wide locations on a simple address, write-strobe and read-data port. Location 0 is a control/status byte holding the rate field, the interrupt enable, a write-one flag acknowledge and the flag itself. Location 1 is a read-only view of the lowest eight chain stages. The chain length is a parameter: the slowest-rate stage for setting 00 is `BASE` and defaults to 14, so the four settings divide the bus clock by 2^14, 2^15, 2^16 and 2^17. The flag edge is taken from the chain increment under the rate that is currently selected, so retuning the rate on the fly can neither invent nor swallow a flag.

Top module: `tick_watchdog`

## Requirements
- R1: Control bits [1:0] at address 0 pick the rate. With value r, the periodic flag sets once every 2^(BASE+r) clock cycles.
- R2: After reset the rate field is 11 (the slowest), the enable and flag are 0 so address 0 reads 8'h03, the count at address 1 reads 0, and irq and wdog_rst are low.
- R3: Address 1 reads the lowest eight chain stages. A read returns the value from the cycle in which addr was presented, and the value advances by one every clock cycle.
- R4: A write to address 1 has no effect. The count keeps its one-per-cycle progression and the control byte is unchanged.
- R5: The flag sets only in a cycle where the selected stage goes from 0 to 1. Changing the rate field does not by itself set the flag.
- R6: The flag, read at bit 7 of address 0, stays set until a write to address 0 with bit 6 = 1. A chain transition in the same cycle as such a clear wins, and the flag remains set.
- R7: irq is high exactly when the flag and the enable (bit 4 of address 0) are both set. It rises in the same cycle as the flag or the enable.
- R8: Without a clear, wdog_rst pulses on every MULT-th (default 8) rising transition of the selected stage. Successive pulses are MULT x 2^(BASE+r) cycles apart.
- R9: wdog_rst is high for exactly one cycle per expiry.
- R10: A wdog_clr strobe zeroes the watchdog stage counter without disturbing the chain. No pulse follows in the next cycle. Clears spaced closer than (MULT-1) periods prevent every expiry, and after a clear the next expiry comes between (MULT-1) and MULT periods later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; drives the chain |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register select: 0 control/status, 1 count |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data for addr |
| wdog_clr | input | 1 | Watchdog clear strobe |
| irq | output | 1 | Periodic interrupt request |
| wdog_rst | output | 1 | One-cycle watchdog expiry pulse |

## Verification
The hardest case to reach is a rate change at a moment when the newly selected stage already sits at 1 while the old one had just risen. A design that only remembers the last sampled tap value would raise a spurious flag there. The bench reaches this situation by waiting for a fast-rate flag, so the chain is known to sit just past a half-period boundary. It then switches at once to each slower rate in turn and repeats this several times, so the slower stages are caught in both states, and it checks that no flag appears before the next legitimate transition. Watchdog timing is measured between consecutive pulses and from a clear to the following pulse.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
  localparam int SEL_W     = 2;
  localparam int NTAPS     = 1 << SEL_W;
  localparam int CTRL_ADDR = 0;
  localparam int CNT_ADDR  = 1;
  localparam int EN_BIT    = 4;
  localparam int CLR_BIT   = 6;
  localparam int FLAG_BIT  = 7;
  typedef logic [SEL_W-1:0] rate_t;
  localparam rate_t RATE_SLOWEST = '1;
endpackage

// File: rtl/tw_chain.sv
`timescale 1ns/1ps
module tw_chain #(
  parameter int BASE  = 14,
  parameter int CNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  tw_pkg::rate_t          sel,
  output logic [CNT_W-1:0]       count,
  output logic                   tick
);
  localparam int CW = BASE + tw_pkg::NTAPS - 1;

  logic [CW-1:0]            chain;
  logic [tw_pkg::NTAPS-1:0] rises;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= chain + CW'(1);
  end

  // Stage T goes 0->1 on the next increment when all lower stages are 1.
  for (genvar i = 0; i < tw_pkg::NTAPS; i++) begin : g_tap
    localparam int T = BASE - 1 + i;
    assign rises[i] = (&chain[T-1:0]) & ~chain[T];
  end

  assign tick  = rises[sel];
  assign count = chain[CNT_W-1:0];
endmodule

// File: rtl/tw_regs.sv
`timescale 1ns/1ps
module tw_regs #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  input  logic [DATA_W-1:0] count,
  output tw_pkg::rate_t     rate_q,
  output logic              en_q,
  output logic              flag_q,
  output logic              irq,
  output logic [DATA_W-1:0] rd_data
);
  import tw_pkg::*;

  logic        ctrl_wr, ack;
  rate_t       rate_d;
  logic        en_d, flag_d;
  logic [DATA_W-1:0] status, rd_next;

  assign ctrl_wr = wr_en && (addr == ADDR_W'(CTRL_ADDR));
  assign ack     = ctrl_wr && wr_data[CLR_BIT];
  assign rate_d  = ctrl_wr ? wr_data[SEL_W-1:0] : rate_q;
  assign en_d    = ctrl_wr ? wr_data[EN_BIT] : en_q;
  assign flag_d  = tick | (flag_q & ~ack);

  always_comb begin
    status               = '0;
    status[SEL_W-1:0]    = rate_q;
    status[EN_BIT]       = en_q;
    status[FLAG_BIT]     = flag_q;
    case (addr)
      ADDR_W'(CTRL_ADDR): rd_next = status;
      ADDR_W'(CNT_ADDR):  rd_next = count;
      default:            rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q  <= RATE_SLOWEST;
      en_q    <= 1'b0;
      flag_q  <= 1'b0;
      irq     <= 1'b0;
      rd_data <= '0;
    end else begin
      rate_q  <= rate_d;
      en_q    <= en_d;
      flag_q  <= flag_d;
      irq     <= flag_d & en_d;
      rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/tw_wdog.sv
`timescale 1ns/1ps
module tw_wdog #(
  parameter int MULT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clr,
  output logic pulse
);
  localparam int CNT_BITS = (MULT > 2) ? $clog2(MULT) : 1;
  localparam logic [CNT_BITS-1:0] LAST = CNT_BITS'(MULT - 1);

  logic [CNT_BITS-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (clr) begin
        stage <= '0;
      end else if (tick) begin
        if (stage == LAST) begin
          stage <= '0;
          pulse <= 1'b1;
        end else begin
          stage <= stage + CNT_BITS'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tick_watchdog.sv
`timescale 1ns/1ps
module tick_watchdog #(
  parameter int BASE   = 14,
  parameter int MULT   = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wdog_clr,
  output logic              irq,
  output logic              wdog_rst
);
  tw_pkg::rate_t     rate;
  logic              tick;
  logic [DATA_W-1:0] count;

  tw_chain #(.BASE(BASE), .CNT_W(DATA_W)) u_chain (
    .clk(clk), .rst(rst), .sel(rate), .count(count), .tick(tick)
  );

  tw_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .tick(tick), .count(count), .rate_q(rate), .en_q(),
    .flag_q(), .irq(irq), .rd_data(rd_data)
  );

  tw_wdog #(.MULT(MULT)) u_wdog (
    .clk(clk), .rst(rst), .tick(tick), .clr(wdog_clr), .pulse(wdog_rst)
  );
endmodule

// File: rtl/tick_watchdog_chk.sv
`timescale 1ns/1ps
module tick_watchdog_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 1
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              wdog_clr,
  input logic              irq,
  input logic              wdog_rst,
  input logic [1:0]        rate,
  input logic [DATA_W-1:0] count,
  input logic              tick,
  input logic              flag,
  input logic              en
);
  // R2: reset leaves the slowest rate, zero count and quiet outputs
  assert_reset_defaults_R2: assert property (@(posedge clk)
    rst |=> (rate == 2'b11 && count == '0 && !irq && !wdog_rst));

  // R3: the visible count advances by one per cycle
  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> count == DATA_W'($past(count) + DATA_W'(1)));

  // R5: the flag only sets on a selected stage transition
  assert_flag_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(tick));

  // R6: the flag only falls after an acknowledge write
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(wr_en && addr == ADDR_W'(0) && wr_data[6]));

  // R7: the interrupt needs both flag and enable
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag && en));

  // R9: expiry pulse lasts one cycle
  assert_pulse_width_R9: assert property (@(posedge clk) disable iff (rst)
    wdog_rst |=> !wdog_rst);

  // R10: a clear suppresses a pulse in the following cycle
  assert_clear_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    wdog_clr |=> !wdog_rst);
endmodule

bind tick_watchdog tick_watchdog_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .wdog_clr(wdog_clr), .irq(irq), .wdog_rst(wdog_rst), .rate(rate),
  .count(count), .tick(tick), .flag(u_regs.flag_q), .en(u_regs.en_q)
);

// File: tb/tick_watchdog_test.sv
`timescale 1ns/1ps
module tick_watchdog_test;
  localparam int BASE = 9;
  localparam int MULT = 8;
  localparam logic [7:0] EN  = 8'h10;
  localparam logic [7:0] ACK = 8'h40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [0:0] addr = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       wdog_clr = 1'b0;
  logic       irq, wdog_rst;

  int  checks = 0;
  int  errors = 0;
  longint cyc = 0;

  tick_watchdog #(.BASE(BASE), .MULT(MULT)) uut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .wdog_clr(wdog_clr), .irq(irq), .wdog_rst(wdog_rst)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint per(input int r);
    return longint'(1) << (BASE + r);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    addr = a;
    @(posedge clk); @(negedge clk);
    v = rd_data;
  endtask

  task automatic clr_wdog();
    wdog_clr = 1'b1;
    @(posedge clk); @(negedge clk);
    wdog_clr = 1'b0;
  endtask

  task automatic wait_irq(output longint t);
    for (int i = 0; i < 20000 && !irq; i++) @(negedge clk);
    t = cyc;
  endtask

  task automatic wait_pulse(output longint t);
    for (int i = 0; i < 40000 && !wdog_rst; i++) @(negedge clk);
    t = cyc;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    repeat (4) @(negedge clk);
    check(!irq && !wdog_rst, "R2 outputs low in reset", {irq, wdog_rst}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(rd_data == 8'h00, "R2 count zero after reset", rd_data, 0);
    rd(1'b0, v);
    check(v == 8'h03, "R2 control default", v, 3);
  endtask

  task automatic t_count();
    logic [7:0] c1, c2, v;
    addr = 1'b1;
    @(negedge clk); c1 = rd_data;
    repeat (37) @(negedge clk);
    c2 = rd_data;
    check(8'(c2 - c1) == 8'd37, "R3 count step", 8'(c2 - c1), 37);
    wr(1'b0, 8'h01);
    addr = 1'b1; @(negedge clk); c1 = rd_data;
    wr(1'b1, 8'hA5);
    repeat (36) @(negedge clk);
    c2 = rd_data;
    check(8'(c2 - c1) == 8'd37, "R4 write to count ignored", 8'(c2 - c1), 37);
    rd(1'b0, v);
    check(v[1:0] == 2'b01 && !v[4], "R4 control untouched", v, 1);
  endtask

  task automatic t_period(input int r);
    longint t1, t2;
    wr(1'b0, 8'(r) | EN | ACK);
    wait_irq(t1);
    wr(1'b0, 8'(r) | EN | ACK);
    wait_irq(t2);
    check(t2 - t1 == per(r), $sformatf("R1 period rate %0d", r), t2 - t1, per(r));
    wr(1'b0, 8'(r) | ACK);
  endtask

  task automatic t_flag_enable();
    longint t;
    logic [7:0] v;
    wr(1'b0, EN | ACK);
    wait_irq(t);
    check(irq, "R7 irq with flag and enable", irq, 1);
    wr(1'b0, 8'h00);
    check(!irq, "R7 irq drops with enable", irq, 0);
    repeat (2 * per(0)) @(negedge clk);
    rd(1'b0, v);
    check(v[7], "R6 flag held without ack", v[7], 1);
    wr(1'b0, ACK);
    rd(1'b0, v);
    check(!v[7], "R6 flag cleared by ack", v[7], 0);
    repeat (per(0)) @(negedge clk);
    rd(1'b0, v);
    check(v[7] && !irq, "R7 flag set but irq masked", {v[7], irq}, 2);
    wr(1'b0, EN);
    check(irq, "R7 irq when enable set late", irq, 1);
    wr(1'b0, ACK);
  endtask

  task automatic t_rate_switch();
    longint t;
    for (int k = 0; k < 6; k++) begin
      int tgt = 1 + (k % 3);
      wr(1'b0, EN | ACK);
      wait_irq(t);
      wr(1'b0, 8'(tgt) | EN | ACK);
      repeat (100) @(negedge clk);
      check(!irq, $sformatf("R5 no flag from switch to rate %0d", tgt), irq, 0);
    end
    wr(1'b0, ACK);
  endtask

  task automatic t_wdog_expire();
    longint tc, t1, t2;
    wr(1'b0, ACK);
    tc = cyc;
    clr_wdog();
    wait_pulse(t1);
    check(t1 - tc >= (MULT - 1) * per(0) && t1 - tc <= MULT * per(0) + 2,
          "R10 expiry window after clear", t1 - tc, MULT * per(0));
    @(negedge clk);
    check(!wdog_rst, "R9 pulse one cycle", wdog_rst, 0);
    wait_pulse(t2);
    check(t2 - t1 == MULT * per(0), "R8 expiry spacing", t2 - t1, MULT * per(0));
  endtask

  task automatic t_wdog_kept();
    int seen = 0;
    logic [7:0] c1, c2;
    for (int k = 0; k < 12; k++) begin
      clr_wdog();
      for (int i = 0; i < 1000; i++) begin
        @(negedge clk);
        if (wdog_rst) seen++;
      end
    end
    check(seen == 0, "R10 clears prevent expiry", seen, 0);
    addr = 1'b1; @(negedge clk); c1 = rd_data;
    clr_wdog();
    repeat (36) @(negedge clk);
    c2 = rd_data;
    check(8'(c2 - c1) == 8'd37, "R10 clear leaves chain running", 8'(c2 - c1), 37);
  endtask

  initial begin
    t_reset();
    t_count();
    for (int r = 0; r < 4; r++) t_period(r);
    t_flag_enable();
    t_rate_switch();
    t_wdog_expire();
    t_wdog_kept();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog timeout actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule